// File: doc/BRIEF.md
# Serial Threshold Offset Loader

This block sets the two threshold offsets, X and Y, that a FIFO flag unit compares against its fill level. The offsets arrive one bit at a time on a serial data pin. The FIFO's write-port clock times each bit, and an active-low serial-enable pin qualifies it. The same two pins choose the mode. Serial programming is selected when both pins are held high while reset is released. If it is not selected, the offsets keep their parameter defaults.

All bits go into a single shift chain. The Y offset fills first, most significant bit first, and the X offset fills last. A counter stops the chain once `2*log2(DEPTH)` bits are in. The input-ready flag stays low for the whole load and rises one write-clock edge after the final bit. From then until the next reset, further serial-enable activity has no effect.

Top module: `offset_serial_loader`

## Requirements
- R1: While `rst_n` is low, every rising `clk` edge samples the mode. The value taken at the last such edge before `rst_n` goes high applies. Serial mode is chosen only when `sdata` and `sen_n` are both 1 at that edge; the other three pin combinations choose default mode.
- R2: While `rst_n` is low, `ready` is 0, `x_off` equals `DEF_X` and `y_off` equals `DEF_Y`.
- R3: In serial mode, each rising `clk` edge with `sen_n` = 0 shifts `sdata` into bit 0 of the chain `{y_off, x_off}`. Existing bits move one place toward the MSB of `y_off`. So the first bit ends up as the MSB of `y_off` and the last bit as the LSB of `x_off`.
- R4: Exactly `2*log2(DEPTH)` bits are taken (20 for DEPTH = 1024). Edges with `sen_n` = 0 after that count leave both offsets unchanged.
- R5: A rising `clk` edge with `sen_n` = 1 captures nothing, whatever the value of `sdata`.
- R6: In serial mode, `ready` stays 0 until the final bit is captured. It stays 0 in the cycle after that capture and becomes 1 at the next rising `clk` edge.
- R7: In default mode, `ready` becomes 1 at the first rising `clk` edge after reset is released. The offsets keep their defaults regardless of `sen_n` and `sdata`.
- R8: Once `ready` is 1, it stays 1 until `rst_n` goes low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-port clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is sampled while it is low |
| sdata | input | 1 | Serial data bit; also one of the two mode-select pins during reset |
| sen_n | input | 1 | Active-low serial enable; also one of the two mode-select pins during reset |
| x_off | output | log2(DEPTH) | X threshold offset |
| y_off | output | log2(DEPTH) | Y threshold offset |
| ready | output | 1 | Input-ready flag; high once programming is complete |

## Verification
A wrong mode latch shows within one cycle of reset release. In that case `ready` either rises at the first edge in serial mode or stays low in default mode. A bit counter that is off by one moves `ready` one cycle early or late, or lets a trailing bit shift the offsets. A wrong shift direction or bit order shows up as an X LSB that does not follow the previous bit, and as final offsets that do not match the values sent. The bench therefore samples `ready` and `x_off[0]` after every bit, and compares the full offsets once loading completes.

// File: rtl/offset_serial_loader.sv
module offset_serial_loader #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned DEF_X = 16,
  parameter int unsigned DEF_Y = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned NBITS = 2 * AW,
  localparam int unsigned CW    = $clog2(NBITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sdata,
  input  logic          sen_n,
  output logic [AW-1:0] x_off,
  output logic [AW-1:0] y_off,
  output logic          ready
);

  localparam logic [CW-1:0] LAST = CW'(NBITS);

  logic             serial_q;
  logic [CW-1:0]    cnt;
  logic [NBITS-1:0] chain;
  logic             take, done;

  assign done = !serial_q || (cnt == LAST);
  assign take = serial_q && !sen_n && (cnt != LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serial_q <= sdata & sen_n;
      cnt      <= '0;
      chain    <= {AW'(DEF_Y), AW'(DEF_X)};
      ready    <= 1'b0;
    end else begin
      if (take) begin
        chain <= {chain[NBITS-2:0], sdata};
        cnt   <= cnt + 1'b1;
      end
      ready <= done;
    end
  end

  assign y_off = chain[NBITS-1:AW];
  assign x_off = chain[AW-1:0];

endmodule

// File: rtl/offset_serial_loader_chk.sv
module offset_serial_loader_chk #(
  parameter int unsigned AW = 10,
  parameter int unsigned NBITS = 20,
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sdata,
  input logic          sen_n,
  input logic          serial_q,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] x_off,
  input logic [AW-1:0] y_off,
  input logic          ready
);
  localparam logic [CW-1:0] LAST = CW'(NBITS);

  AST_RESET_NOT_READY: assert property (@(posedge clk) !rst_n |=> !ready); // R2
  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_q && !sen_n && cnt != LAST) |=> x_off[0] == $past(sdata)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST); // R4
  AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST) |=> $stable({y_off, x_off})); // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_n || !serial_q) |=> $stable({y_off, x_off})); // R5
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(cnt == LAST || !serial_q)); // R6
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R8
endmodule

bind offset_serial_loader offset_serial_loader_chk #(.AW(AW), .NBITS(NBITS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdata(sdata), .sen_n(sen_n), .serial_q(serial_q),
  .cnt(cnt), .x_off(x_off), .y_off(y_off), .ready(ready)
);

// File: tb/test_offset_serial_loader.sv
module test_offset_serial_loader;
  localparam int DEPTH = 1024;
  localparam int DEF_X = 16;
  localparam int DEF_Y = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int NBITS = 2 * AW;

  logic clk = 0, rst_n = 0, sdata = 0, sen_n = 1;
  logic [AW-1:0] x_off, y_off;
  logic ready;
  int tests = 0, fails = 0;

  offset_serial_loader #(.DEPTH(DEPTH), .DEF_X(DEF_X), .DEF_Y(DEF_Y)) i_offset_serial_loader (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .sen_n(sen_n),
    .x_off(x_off), .y_off(y_off), .ready(ready));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rand_off();
    return 1 + $urandom_range(DEPTH - 5);
  endfunction

  function automatic bit is_serial(input bit sd, input bit se);
    return sd & se;
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset(input bit sd, input bit se);
    @(negedge clk);
    rst_n = 0; sdata = ~sd; sen_n = ~se;
    step();
    sdata = sd; sen_n = se;
    step(); step();
    chk("R2 ready in reset", ready, 0);
    chk("R2 x default", x_off, DEF_X);
    chk("R2 y default", y_off, DEF_Y);
    rst_n = 1;
  endtask

  task automatic load(input int xv, input int yv, input int maxgap);
    logic [NBITS-1:0] s;
    s = {yv[AW-1:0], xv[AW-1:0]};
    for (int i = NBITS - 1; i >= 0; i--) begin
      int g;
      g = (maxgap > 0) ? $urandom_range(maxgap) : 0;
      for (int k = 0; k < g; k++) begin
        sen_n = 1; sdata = $urandom_range(1);
        step();
        chk("R5 no capture while disabled", ready, 0);
      end
      sen_n = 0; sdata = s[i];
      step();
      chk("R3 lsb follows bit", x_off[0], s[i]);
      chk("R6 ready low while loading", ready, 0);
    end
    sen_n = 1; sdata = 0;
    step();
    chk("R6 ready after last bit", ready, 1);
    chk("R3 x offset", x_off, xv);
    chk("R3 y offset", y_off, yv);
  endtask

  task automatic trailing(input int xv, input int yv);
    for (int k = 0; k < 5; k++) begin
      sen_n = $urandom_range(1); sdata = $urandom_range(1);
      step();
      chk("R4 x frozen after count", x_off, xv);
      chk("R4 y frozen after count", y_off, yv);
      chk("R8 ready stays", ready, 1);
    end
    sen_n = 1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(1, 1);
    load(1, DEPTH - 4, 0); trailing(1, DEPTH - 4);
    do_reset(1, 1);
    load(DEPTH - 4, 1, 2); trailing(DEPTH - 4, 1);
    for (int n = 0; n < 6; n++) begin
      int xv, yv;
      xv = rand_off(); yv = rand_off();
      do_reset(1, 1);
      load(xv, yv, 3); trailing(xv, yv);
    end
    for (int m = 0; m < 3; m++) begin
      bit sd, se;
      sd = (m != 0); se = (m != 1);
      if (m == 2) begin sd = 0; se = 0; end
      do_reset(sd, se);
      chk("R1 mode decode", int'(is_serial(sd, se)), 0);
      sen_n = 0; sdata = 1;
      step();
      chk("R7 ready at first edge", ready, 1);
      chk("R1 default mode taken", ready, 1);
      for (int k = 0; k < NBITS + 2; k++) begin
        sen_n = $urandom_range(1); sdata = $urandom_range(1);
        step();
        chk("R7 x default kept", x_off, DEF_X);
        chk("R7 y default kept", y_off, DEF_Y);
        chk("R8 ready stays", ready, 1);
      end
      sen_n = 1;
    end
    do_reset(1, 1);
    sen_n = 1;
    step();
    chk("R1 serial mode holds ready low", ready, 0);
    load(5, 7, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule